// File: doc/BRIEF.md
# Exception Prioritiser and Entry Controller

This block sits beside a processor core's pipeline and turns pending exception conditions into a complete entry step. It watches six request lines:
- reset
- data abort
- fast interrupt
- normal interrupt
- prefetch abort
- a shared trap line that carries either a software interrupt or an undefined instruction

In each cycle it picks the most urgent request that is allowed to be taken. On the next clock edge it presents:
- the handler address
- the status word the handler starts with
- write strobes and data for the entered mode's banked link register and saved status register

The core supplies the address of the current instruction and the current status word. The core's register file consumes the strobes, and the core jumps to the new PC. Decoding instructions, holding the registers and returning from a handler are left to the surrounding logic.

The status word layout is fixed:
- bits [4:0] hold the mode
- bit 5 is the compressed (16-bit) instruction-state flag
- bit 6 disables fast interrupts
- bit 7 disables normal interrupts

Upper bits are condition flags that the block passes through unchanged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Simultaneous requests resolve by fixed priority, from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, trap. Only the winner is entered.
- R2: The new PC is VEC_BASE plus an offset for the winner: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: The mode field new_psr[4:0] becomes the mode entered. Reset and software interrupt enter supervisor (10011). Both aborts enter abort (10111). Undefined enters undef (11011). Fast interrupt enters 10001, and normal interrupt enters 10010. The same code appears on lr_mode and spsr_mode.
- R4: The link value is the current PC plus 8 for a data abort, and plus 4 for a fast interrupt, a normal interrupt or a prefetch abort.
- R5: For a trap, the link value is the current PC plus 4 when cur_psr[5] is 0, and plus 2 when cur_psr[5] is 1.
- R6: Every non-reset entry pulses lr_we and spsr_we together, and spsr_data equals the status word sampled at the request. Reset entry writes neither register.
- R7: Every entry sets new_psr[7]. Fast-interrupt and reset entries also set new_psr[6]. Any other entry keeps bit 6 as it was in cur_psr.
- R8: Entry clears new_psr[5] and passes new_psr[XLEN-1:8] through from cur_psr.
- R9: A fast request is ignored while cur_psr[6] is 1, and a normal request is ignored while cur_psr[7] is 1. A masked request lets the next lower pending request win. Aborts, reset and traps are never masked.
- R10: entry_done pulses for exactly the one cycle after a cycle in which some request was taken. It stays low after a cycle with no takeable request.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| evt_reset | input | 1 | Reset exception request |
| evt_dabort | input | 1 | Data abort request |
| evt_fast | input | 1 | Fast interrupt request |
| evt_norm | input | 1 | Normal interrupt request |
| evt_pabort | input | 1 | Prefetch abort request |
| evt_trap | input | 1 | Software interrupt or undefined instruction request |
| trap_is_undef | input | 1 | 1: the trap is an undefined instruction; 0: it is a software interrupt |
| cur_pc | input | XLEN | Address used as the base of the link value |
| cur_psr | input | XLEN | Current status word |
| entry_done | output | 1 | One-cycle pulse marking an entry |
| new_pc | output | XLEN | Handler address |
| new_psr | output | XLEN | Status word for the handler |
| lr_we | output | 1 | Banked link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | XLEN | Link value |
| spsr_we | output | 1 | Saved status register write strobe |
| spsr_mode | output | 5 | Mode whose saved status register is written |
| spsr_data | output | XLEN | Copy of the old status word |

## Verification
The bench builds the block with XLEN at 32 and VEC_BASE at 0xFFFF0000. With a base other than zero, a dropped base term or an offset applied to the wrong bits shows up directly on new_pc. Every priority level is reached by stacking all lower requests under it. Status words are chosen with flag bits set in the upper byte and with each mask bit set on its own. This exposes lost pass-through bits and lets a masked request fall through to the trap, or to no entry at all. Both instruction states are applied to each trap kind, so the half-length link offset is exercised.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_reset,
  input  logic            evt_dabort,
  input  logic            evt_fast,
  input  logic            evt_norm,
  input  logic            evt_pabort,
  input  logic            evt_trap,
  input  logic            trap_is_undef,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psr,
  output logic            entry_done,
  output logic [XLEN-1:0] new_pc,
  output logic [XLEN-1:0] new_psr,
  output logic            lr_we,
  output logic [4:0]      lr_mode,
  output logic [XLEN-1:0] lr_data,
  output logic            spsr_we,
  output logic [4:0]      spsr_mode,
  output logic [XLEN-1:0] spsr_data
);

  localparam int TBIT = 5;
  localparam int FBIT = 6;
  localparam int IBIT = 7;

  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;

  wire fast_ok = evt_fast & ~cur_psr[FBIT];
  wire norm_ok = evt_norm & ~cur_psr[IBIT];

  logic            take;
  logic            is_rst;
  logic            set_f;
  logic [4:0]      mode;
  logic [4:0]      voff;
  logic [3:0]      loff;

  always_comb begin
    take   = 1'b1;
    is_rst = 1'b0;
    set_f  = 1'b0;
    mode   = M_SVC;
    voff   = 5'h00;
    loff   = 4'd4;
    if (evt_reset) begin
      is_rst = 1'b1;
      set_f  = 1'b1;
      loff   = 4'd0;
    end else if (evt_dabort) begin
      mode = M_ABT;
      voff = 5'h10;
      loff = 4'd8;
    end else if (fast_ok) begin
      mode  = M_FIQ;
      voff  = 5'h1C;
      set_f = 1'b1;
    end else if (norm_ok) begin
      mode = M_IRQ;
      voff = 5'h18;
    end else if (evt_pabort) begin
      mode = M_ABT;
      voff = 5'h0C;
    end else if (evt_trap) begin
      mode = trap_is_undef ? M_UND : M_SVC;
      voff = trap_is_undef ? 5'h04 : 5'h08;
      loff = cur_psr[TBIT] ? 4'd2 : 4'd4;
    end else begin
      take = 1'b0;
    end
  end

  wire [XLEN-1:0] psr_next = {cur_psr[XLEN-1:8], 1'b1, set_f | cur_psr[FBIT], 1'b0, mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_done <= 1'b0;
      new_pc     <= '0;
      new_psr    <= '0;
      lr_we      <= 1'b0;
      lr_mode    <= '0;
      lr_data    <= '0;
      spsr_we    <= 1'b0;
      spsr_mode  <= '0;
      spsr_data  <= '0;
    end else begin
      entry_done <= take;
      lr_we      <= take & ~is_rst;
      spsr_we    <= take & ~is_rst;
      if (take) begin
        new_pc    <= VEC_BASE + XLEN'(voff);
        new_psr   <= psr_next;
        lr_mode   <= mode;
        spsr_mode <= mode;
        lr_data   <= cur_pc + XLEN'(loff);
        spsr_data <= cur_psr;
      end
    end
  end

  assert_bank_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (spsr_we && lr_mode == spsr_mode));

  assert_saved_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> spsr_data == $past(cur_psr));

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> new_psr[IBIT]);

  assert_wide_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> !new_psr[TBIT]);

  assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reset |=> (entry_done && new_pc == VEC_BASE && !lr_we && !spsr_we));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_reset || evt_dabort || evt_fast || evt_norm || evt_pabort || evt_trap) |=> !entry_done);

  assert_fast_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fast && cur_psr[FBIT] && !evt_reset && !evt_dabort && !evt_norm && !evt_pabort && !evt_trap)
      |=> !entry_done);

endmodule

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] BASE = 32'hFFFF_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic e_rst = 0, e_dab = 0, e_fiq = 0, e_irq = 0, e_pab = 0, e_trp = 0, undef = 0;
  logic [XLEN-1:0] pc = '0, psr = '0;
  logic entry_done, lr_we, spsr_we;
  logic [XLEN-1:0] new_pc, new_psr, lr_data, spsr_data;
  logic [4:0] lr_mode, spsr_mode;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl #(.XLEN(XLEN), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n),
    .evt_reset(e_rst), .evt_dabort(e_dab), .evt_fast(e_fiq), .evt_norm(e_irq),
    .evt_pabort(e_pab), .evt_trap(e_trp), .trap_is_undef(undef),
    .cur_pc(pc), .cur_psr(psr),
    .entry_done(entry_done), .new_pc(new_pc), .new_psr(new_psr),
    .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
    .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_data(spsr_data)
  );

  typedef struct {
    logic            done;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] psr;
    logic            wr;
    logic [4:0]      mode;
    logic [XLEN-1:0] link;
    logic [XLEN-1:0] saved;
    string           tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input bit r, input bit d, input bit f, input bit i,
                       input bit p, input bit t, input bit u,
                       input logic [XLEN-1:0] a_pc, input logic [XLEN-1:0] a_psr,
                       input string tag);
    exp_t e;
    bit fa, ia;
    @(negedge clk);
    e_rst = r; e_dab = d; e_fiq = f; e_irq = i; e_pab = p; e_trp = t; undef = u;
    pc = a_pc; psr = a_psr;
    fa = f && !a_psr[6];
    ia = i && !a_psr[7];
    e.tag = tag;
    e.done = 1'b1;
    e.wr = 1'b1;
    e.saved = a_psr;
    e.psr = a_psr;
    e.psr[7] = 1'b1;
    e.psr[5] = 1'b0;
    if (r) begin
      e.wr = 1'b0; e.mode = 5'b10011; e.pc = BASE; e.psr[6] = 1'b1; e.link = '0;
    end else if (d) begin
      e.mode = 5'b10111; e.pc = BASE + 32'h10; e.link = a_pc + 8;
    end else if (fa) begin
      e.mode = 5'b10001; e.pc = BASE + 32'h1C; e.link = a_pc + 4; e.psr[6] = 1'b1;
    end else if (ia) begin
      e.mode = 5'b10010; e.pc = BASE + 32'h18; e.link = a_pc + 4;
    end else if (p) begin
      e.mode = 5'b10111; e.pc = BASE + 32'h0C; e.link = a_pc + 4;
    end else if (t) begin
      e.mode = u ? 5'b11011 : 5'b10011;
      e.pc = BASE + (u ? 32'h04 : 32'h08);
      e.link = a_pc + (a_psr[5] ? 2 : 4);
    end else begin
      e.done = 1'b0; e.wr = 1'b0; e.mode = '0; e.pc = '0; e.link = '0;
    end
    e.psr[4:0] = e.mode;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(entry_done == e.done, e.tag, "entry_done", XLEN'(entry_done), XLEN'(e.done));
        chk(lr_we == e.wr, e.tag, "lr_we", XLEN'(lr_we), XLEN'(e.wr));
        chk(spsr_we == e.wr, e.tag, "spsr_we", XLEN'(spsr_we), XLEN'(e.wr));
        if (e.done) begin
          chk(new_pc == e.pc, e.tag, "new_pc", new_pc, e.pc);
          chk(new_psr == e.psr, e.tag, "new_psr", new_psr, e.psr);
        end
        if (e.wr) begin
          chk(lr_mode == e.mode, e.tag, "lr_mode", XLEN'(lr_mode), XLEN'(e.mode));
          chk(spsr_mode == e.mode, e.tag, "spsr_mode", XLEN'(spsr_mode), XLEN'(e.mode));
          chk(lr_data == e.link, e.tag, "lr_data", lr_data, e.link);
          chk(spsr_data == e.saved, e.tag, "spsr_data", spsr_data, e.saved);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R11: outputs held at zero while in reset
    chk({entry_done, lr_we, spsr_we} == 3'b000 && new_pc == '0 && new_psr == '0
        && lr_data == '0 && spsr_data == '0, "R11", "reset outputs",
        new_pc | new_psr | XLEN'({entry_done, lr_we, spsr_we}), '0);
    rst_n = 1'b1;

    // R10: idle produces no entry
    apply(0,0,0,0,0,0,0, 32'h100, 32'h0000_0010, "R10 idle");
    // R2 R3 R4: single requests
    apply(0,1,0,0,0,0,0, 32'h1000, 32'h0000_0010, "R4 data abort");
    apply(0,0,1,0,0,0,0, 32'h2000, 32'h0000_0010, "R2 fast");
    apply(0,0,0,1,0,0,0, 32'h3000, 32'h0000_0010, "R3 normal");
    apply(0,0,0,0,1,0,0, 32'h4000, 32'h0000_0010, "R4 prefetch abort");
    // R5: traps in both instruction states
    apply(0,0,0,0,0,1,0, 32'h5000, 32'h0000_0010, "R5 swi wide");
    apply(0,0,0,0,0,1,1, 32'h5100, 32'h0000_0010, "R5 undef wide");
    apply(0,0,0,0,0,1,0, 32'h5202, 32'h0000_0030, "R5 swi compressed");
    apply(0,0,0,0,0,1,1, 32'h5302, 32'h0000_0030, "R5 undef compressed");
    // R1: priority ladder
    apply(1,1,1,1,1,1,0, 32'h6000, 32'h0000_0010, "R1 reset wins");
    apply(0,1,1,1,1,1,0, 32'h6100, 32'h0000_0010, "R1 dabort wins");
    apply(0,0,1,1,1,1,1, 32'h6200, 32'h0000_0010, "R1 fast wins");
    apply(0,0,0,1,1,1,1, 32'h6300, 32'h0000_0010, "R1 normal wins");
    apply(0,0,0,0,1,1,1, 32'h6400, 32'h0000_0010, "R1 pabort wins");
    // R9: masking and fall-through
    apply(0,0,1,1,0,0,0, 32'h7000, 32'h0000_0050, "R9 fast masked normal taken");
    apply(0,0,1,1,0,1,1, 32'h7100, 32'h0000_00D0, "R9 both masked trap taken");
    apply(0,0,0,1,0,0,0, 32'h7200, 32'h0000_0090, "R9 normal masked no entry");
    apply(0,0,1,0,0,0,0, 32'h7300, 32'h0000_0050, "R9 fast masked no entry");
    apply(0,1,0,0,0,0,0, 32'h7400, 32'h0000_00D0, "R9 abort unmasked");
    // R7 R8: flag pass-through and mask bits
    apply(0,0,0,1,0,0,0, 32'h8000, 32'hA000_0050, "R7 normal keeps F");
    apply(0,0,0,0,1,0,0, 32'h8100, 32'hF000_0030, "R8 flags kept T cleared");
    apply(1,0,0,0,0,0,0, 32'h8200, 32'h5000_0010, "R6 reset no writes");
    // R10: entry followed by idle
    apply(0,0,0,0,0,0,0, 32'h9000, 32'h0000_0010, "R10 pulse ends");

    @(negedge clk);
    e_rst = 0; e_dab = 0; e_fiq = 0; e_irq = 0; e_pab = 0; e_trp = 0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule